// File: doc/BRIEF.md
# Frame Interval Monitor

This block watches the frame-sync events of a video capture path and measures the time between consecutive events in whole microseconds. A prescaler turns the core clock into microsecond ticks. A saturating counter restarts at every event, and its value at the next event is one interval sample. After each restart a set number of intervals is thrown away while the incoming stream settles. Samples above a hard ceiling are discarded, because they usually come from a stalled source rather than from a timing fault. Each time a power-of-two number of accepted samples has been gathered, their average is compared with the nominal frame interval. If the average lies outside a tolerance band, an error pulse is raised.

The trigger can come from an external sync line or from an internal end-of-frame strobe. The sync line passes through a two-flop synchronizer and an edge selector. Edge mode 0 (off) uses the strobe. Mode 1 uses rising edges, mode 2 falling edges and mode 3 both edges of the sync line. The monitor can be switched off as a whole. If any setting changes while it is on, it restarts at once under the new settings.

The control state machine has four states: `ST_IDLE` (switched off), `ST_ARM` (waiting for the first event, which only starts the timer), `ST_SKIP` (discarding settling intervals) and `ST_ACCUM` (gathering samples). Its transitions are:
- IDLE→ARM when enabled.
- ARM→SKIP on an event when the skip count is non-zero, and ARM→ACCUM on an event when it is zero.
- SKIP→ACCUM on the event that completes the skip count.
- Any state→ARM on a setting change while enabled.
- Any state→IDLE when disabled.

ACCUM stays in ACCUM after each average.

Top module: `frame_gap_monitor`

## Requirements
- R1: After reset with the monitor disabled, `avg_interval` is 0 and `avg_strobe`, `err_pulse` and `settling` are all 0.
- R2: An interval sample is floor(D / CLK_PER_US), where D is the number of clock cycles between two consecutive accepted events. The first event after arming yields no sample.
- R3: `cfg_edge` encodes the trigger: 0 uses `eof_strobe` and ignores `sync_in`; 1 uses rising edges of `sync_in`; 2 uses falling edges; 3 uses both edges. Edges that the selected mode does not name cause no event.
- R4: After the arming event, the next `cfg_skip` intervals are discarded. `settling` is 1 in ARM and SKIP and 0 once gathering has begun.
- R5: After 2^`cfg_avg_log2` accepted samples, `avg_interval` takes their sum shifted right by `cfg_avg_log2` (truncated), and `avg_strobe` pulses for one cycle. Gathering then starts again from zero.
- R6: A sample larger than `cfg_tol_max` is discarded. A sample equal to it is accepted.
- R7: `err_pulse` pulses together with `avg_strobe` exactly when |average − `cfg_nominal`| > `cfg_tol_min`. A difference equal to the tolerance raises no error.
- R8: A change of any `cfg_*` field other than `cfg_enable` while enabled discards the partial group and returns to ARM on the next clock edge.
- R9: While `cfg_enable` is 0, the block stays in IDLE: no `avg_strobe`, no `err_pulse`, and `settling` is 0.
- R10: The interval counter saturates at 2^IVL_W − 1, so a longer interval is reported as that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Asynchronous frame-sync line |
| eof_strobe | input | 1 | One-cycle internal end-of-frame strobe |
| cfg_enable | input | 1 | Monitor on/off |
| cfg_edge | input | 2 | Trigger select (0 strobe, 1 rise, 2 fall, 3 both) |
| cfg_avg_log2 | input | SHIFT_W | log2 of samples per average |
| cfg_tol_min | input | IVL_W | Allowed deviation from nominal, µs |
| cfg_tol_max | input | IVL_W | Sample ceiling, µs |
| cfg_skip | input | SKIP_W | Intervals discarded after arming |
| cfg_nominal | input | IVL_W | Nominal frame interval, µs |
| avg_interval | output | IVL_W | Most recent averaged interval, µs |
| avg_strobe | output | 1 | One-cycle pulse when `avg_interval` updates |
| err_pulse | output | 1 | One-cycle error event |
| settling | output | 1 | High while arming or skipping |

## Verification
The assertions assume that trigger events are at least two clock cycles apart. They also assume that settings change only between events or while the monitor is disabled.

The stimulus spaces events by tens to hundreds of microseconds. It changes settings with the monitor disabled, except in the one restart case, where the change falls in the middle of a gap. It restores the sync level three cycles after each edge in the single-edge modes. As a result, every sample equals the intended number of microseconds exactly, and the expected averages can be computed from the microsecond values alone.

// File: rtl/fgm_pkg.sv
package fgm_pkg;

    // Trigger source select; the value is the cfg_edge encoding.
    typedef enum logic [1:0] {
        FGM_EDGE_OFF  = 2'd0,
        FGM_EDGE_RISE = 2'd1,
        FGM_EDGE_FALL = 2'd2,
        FGM_EDGE_BOTH = 2'd3
    } fgm_edge_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SKIP  = 2'd2,
        ST_ACCUM = 2'd3
    } fgm_state_e;

endpackage

// File: rtl/fgm_edge_sel.sv
module fgm_edge_sel
    import fgm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_in,
    input  logic      eof_strobe,
    input  fgm_edge_e edge_mode,
    output logic      ev
);

    logic meta_q, sync_q, prev_q;
    logic hit;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= sync_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        unique case (edge_mode)
            FGM_EDGE_OFF:  hit = eof_strobe;
            FGM_EDGE_RISE: hit = sync_q & ~prev_q;
            FGM_EDGE_FALL: hit = ~sync_q & prev_q;
            FGM_EDGE_BOTH: hit = sync_q ^ prev_q;
            default:       hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev <= 1'b0;
        else        ev <= hit;
    end

    AST_OFF_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode == FGM_EDGE_OFF && !eof_strobe) |=> !ev); // R3

endmodule

// File: rtl/fgm_timebase.sv
module fgm_timebase #(
    parameter int CLK_PER_US = 250, // must be 2 or more
    parameter int IVL_W      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    output logic [IVL_W-1:0] us_cnt
);

    localparam int              PRE_W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_US - 1);
    localparam logic [IVL_W-1:0] MAXV = {IVL_W{1'b1}};

    logic [PRE_W-1:0] pre_q;

    // An event restarts the prescaler at phase 1 so that a gap of
    // N*CLK_PER_US cycles reads back as exactly N microseconds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            us_cnt <= '0;
        end else if (ev) begin
            pre_q  <= PRE_W'(1);
            us_cnt <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
            if (us_cnt != MAXV) us_cnt <= us_cnt + IVL_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_CLEAR_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (us_cnt == '0)); // R2
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (us_cnt == MAXV && !ev) |=> (us_cnt == MAXV)); // R10

endmodule

// File: rtl/fgm_ctrl.sv
module fgm_ctrl
    import fgm_pkg::*;
#(
    parameter int IVL_W   = 20,
    parameter int SHIFT_W = 3,
    parameter int SKIP_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_changed,
    input  logic               ev,
    input  logic [IVL_W-1:0]   sample,
    input  logic [SHIFT_W-1:0] avg_log2,
    input  logic [IVL_W-1:0]   tol_min,
    input  logic [IVL_W-1:0]   tol_max,
    input  logic [SKIP_W-1:0]  skip_n,
    input  logic [IVL_W-1:0]   nominal,
    output logic [IVL_W-1:0]   avg_interval,
    output logic               avg_strobe,
    output logic               err_pulse,
    output logic               settling
);

    localparam int CNT_W = 2 ** SHIFT_W;
    localparam int ACC_W = IVL_W + CNT_W - 1;

    fgm_state_e state_q, state_d;

    logic [ACC_W-1:0]  acc_q, acc_sum;
    logic [CNT_W-1:0]  n_q, n_goal;
    logic [SKIP_W-1:0] skip_q;
    logic [IVL_W-1:0]  avg, dev;
    logic              restart, take, done;

    assign restart = !enable || cfg_changed;
    assign take    = (state_q == ST_ACCUM) && ev && !restart && (sample <= tol_max);
    assign n_goal  = CNT_W'(1) << avg_log2;
    assign done    = take && ((n_q + CNT_W'(1)) == n_goal);
    assign acc_sum = acc_q + ACC_W'(sample);
    assign avg     = IVL_W'(acc_sum >> avg_log2);
    assign dev     = (avg >= nominal) ? (avg - nominal) : (nominal - avg);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else if (cfg_changed) begin
            state_d = ST_ARM;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ARM;
                ST_ARM:   if (ev) state_d = (skip_n == '0) ? ST_ACCUM : ST_SKIP;
                ST_SKIP:  if (ev && (skip_q + SKIP_W'(1)) == skip_n) state_d = ST_ACCUM;
                ST_ACCUM: state_d = ST_ACCUM;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q        <= '0;
            n_q          <= '0;
            skip_q       <= '0;
            avg_interval <= '0;
            avg_strobe   <= 1'b0;
            err_pulse    <= 1'b0;
        end else begin
            avg_strobe <= done;
            err_pulse  <= done && (dev > tol_min);
            if (done) avg_interval <= avg;

            if (restart || state_q != ST_ACCUM || done) begin
                acc_q <= '0;
                n_q   <= '0;
            end else if (take) begin
                acc_q <= acc_sum;
                n_q   <= n_q + CNT_W'(1);
            end

            if (restart || state_q != ST_SKIP) skip_q <= '0;
            else if (ev)                       skip_q <= skip_q + SKIP_W'(1);
        end
    end

    assign settling = (state_q == ST_ARM) || (state_q == ST_SKIP);

    AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> avg_strobe); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        avg_strobe |=> !avg_strobe); // R5
    AST_AVG_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        avg_strobe |-> (avg_interval <= $past(tol_max))); // R6
    AST_RESTART_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cfg_changed) |=> settling); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!avg_strobe && !settling)); // R9

endmodule

// File: rtl/frame_gap_monitor.sv
module frame_gap_monitor
    import fgm_pkg::*;
#(
    parameter int CLK_PER_US = 250,
    parameter int IVL_W      = 20,
    parameter int SHIFT_W    = 3,
    parameter int SKIP_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_in,
    input  logic               eof_strobe,
    input  logic               cfg_enable,
    input  logic [1:0]         cfg_edge,
    input  logic [SHIFT_W-1:0] cfg_avg_log2,
    input  logic [IVL_W-1:0]   cfg_tol_min,
    input  logic [IVL_W-1:0]   cfg_tol_max,
    input  logic [SKIP_W-1:0]  cfg_skip,
    input  logic [IVL_W-1:0]   cfg_nominal,
    output logic [IVL_W-1:0]   avg_interval,
    output logic               avg_strobe,
    output logic               err_pulse,
    output logic               settling
);

    localparam int CFG_W = 2 + SHIFT_W + 3 * IVL_W + SKIP_W;

    logic [CFG_W-1:0] cfg_vec, snap_q;
    logic             cfg_changed;
    logic             ev;
    logic [IVL_W-1:0] us_cnt;

    assign cfg_vec = {cfg_edge, cfg_avg_log2, cfg_tol_min, cfg_tol_max, cfg_skip, cfg_nominal};

    // Any difference from the previous cycle's settings restarts the monitor.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= cfg_vec;
    end
    assign cfg_changed = (cfg_vec != snap_q);

    fgm_edge_sel u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .eof_strobe (eof_strobe),
        .edge_mode  (fgm_edge_e'(cfg_edge)),
        .ev         (ev)
    );

    fgm_timebase #(.CLK_PER_US(CLK_PER_US), .IVL_W(IVL_W)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .us_cnt (us_cnt)
    );

    fgm_ctrl #(.IVL_W(IVL_W), .SHIFT_W(SHIFT_W), .SKIP_W(SKIP_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (cfg_enable),
        .cfg_changed  (cfg_changed),
        .ev           (ev),
        .sample       (us_cnt),
        .avg_log2     (cfg_avg_log2),
        .tol_min      (cfg_tol_min),
        .tol_max      (cfg_tol_max),
        .skip_n       (cfg_skip),
        .nominal      (cfg_nominal),
        .avg_interval (avg_interval),
        .avg_strobe   (avg_strobe),
        .err_pulse    (err_pulse),
        .settling     (settling)
    );

endmodule

// File: tb/frame_gap_monitor_tb.sv
module frame_gap_monitor_tb;

    localparam int CPU  = 4;
    localparam int IW   = 10;
    localparam int SW   = 3;
    localparam int KW   = 4;
    localparam int MAXV = (1 << IW) - 1;

    localparam int M_OFF = 0, M_RISE = 1, M_FALL = 2, M_BOTH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_in = 1'b0;
    logic          eof_strobe = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [1:0]    cfg_edge = '0;
    logic [SW-1:0] cfg_avg_log2 = '0;
    logic [IW-1:0] cfg_tol_min = '0;
    logic [IW-1:0] cfg_tol_max = '0;
    logic [KW-1:0] cfg_skip = '0;
    logic [IW-1:0] cfg_nominal = '0;
    logic [IW-1:0] avg_interval;
    logic          avg_strobe, err_pulse, settling;

    always #2 clk = ~clk; // 250 MHz

    frame_gap_monitor #(.CLK_PER_US(CPU), .IVL_W(IW), .SHIFT_W(SW), .SKIP_W(KW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .eof_strobe(eof_strobe),
        .cfg_enable(cfg_enable), .cfg_edge(cfg_edge), .cfg_avg_log2(cfg_avg_log2),
        .cfg_tol_min(cfg_tol_min), .cfg_tol_max(cfg_tol_max), .cfg_skip(cfg_skip),
        .cfg_nominal(cfg_nominal), .avg_interval(avg_interval), .avg_strobe(avg_strobe),
        .err_pulse(err_pulse), .settling(settling)
    );

    typedef struct {
        int    avg;
        bit    err;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    ivq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R5";
    int    m_skip, m_log2, m_tmin, m_tmax, m_nom;

    task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Monitor: pops one expected average per strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_pulse && !avg_strobe)
                check(1'b0, "R7", "err_pulse without avg_strobe", 1, 0);
            if (avg_strobe) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9", "unexpected avg_strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(int'(avg_interval) == e.avg, e.tag, "avg_interval", int'(avg_interval), e.avg);
                    check(err_pulse == e.err, "R7", "err_pulse", int'(err_pulse), int'(e.err));
                end
            end
        end
    end

    task automatic set_cfg(input int e, input int l2, input int tmin, input int tmax,
                           input int sk, input int nom, input bit idle_lvl);
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_edge = 2'(e); cfg_avg_log2 = SW'(l2); cfg_tol_min = IW'(tmin);
        cfg_tol_max = IW'(tmax); cfg_skip = KW'(sk); cfg_nominal = IW'(nom);
        m_skip = sk; m_log2 = l2; m_tmin = tmin; m_tmax = tmax; m_nom = nom;
        sync_in = idle_lvl;
        repeat (6) @(negedge clk);
        cfg_enable = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic fire(input int mode);
        case (mode)
            M_RISE:  sync_in = 1'b1;
            M_FALL:  sync_in = 1'b0;
            M_BOTH:  sync_in = ~sync_in;
            default: eof_strobe = 1'b1;
        endcase
    endtask

    task automatic gap(input int mode, input int d);
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            if (k == 1) eof_strobe = 1'b0;
            if (k == 3 && mode == M_RISE) sync_in = 1'b0;
            if (k == 3 && mode == M_FALL) sync_in = 1'b1;
            if (mode == M_OFF && k == d / 2) sync_in = ~sync_in; // noise, must be ignored (R3)
        end
    endtask

    // Driver: arming event, then one event per queued interval (in us).
    task automatic play(input int mode, input bit live);
        int ph = 0, skc = 0, acc = 0, n = 0;
        fire(mode);
        if (live) ph = (m_skip > 0) ? 1 : 2;
        for (int i = 0; i < ivq.size(); i++) begin
            gap(mode, ivq[i] * CPU);
            if (live) begin
                int m;
                m = (ivq[i] > MAXV) ? MAXV : ivq[i];
                if (ph == 1) begin
                    skc++;
                    if (skc == m_skip) ph = 2;
                end else if (m <= m_tmax) begin
                    acc += m;
                    n++;
                    if (n == (1 << m_log2)) begin
                        exp_t e;
                        int   a, dv;
                        a  = acc >> m_log2;
                        dv = (a > m_nom) ? a - m_nom : m_nom - a;
                        e.avg = a; e.err = (dv > m_tmin); e.tag = cur_tag;
                        expq.push_back(e);
                        acc = 0; n = 0;
                    end
                end
            end
            fire(mode);
        end
        gap(mode, 14);
    endtask

    task automatic drained(input string req);
        check(expq.size() == 0, req, "averages still pending", expq.size(), 0);
        expq.delete();
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(avg_interval == '0, "R1", "avg_interval", int'(avg_interval), 0);
        check(!avg_strobe, "R1", "avg_strobe", int'(avg_strobe), 0);
        check(!err_pulse, "R1", "err_pulse", int'(err_pulse), 0);
        check(!settling, "R1", "settling", int'(settling), 0);

        // R2 R5 R7: rising edges, pairs averaged, tolerance 5 around 100
        cur_tag = "R2 R5";
        set_cfg(M_RISE, 1, 5, MAXV, 0, 100, 1'b0);
        check(settling, "R4", "settling while armed", int'(settling), 1);
        ivq = '{100, 100, 104, 106, 90, 90, 95, 94};
        play(M_RISE, 1'b1);
        drained("R5");

        // R4 skip still in progress
        cur_tag = "R4";
        set_cfg(M_RISE, 0, 0, MAXV, 3, 50, 1'b0);
        ivq = '{50, 50};
        play(M_RISE, 1'b1);
        check(settling, "R4", "settling during skip", int'(settling), 1);
        drained("R4");

        // R4 R3: falling edges, skip 2, average of 4 with truncation
        set_cfg(M_FALL, 2, 0, MAXV, 2, 41, 1'b1);
        ivq = '{50, 60, 40, 41, 42, 43};
        play(M_FALL, 1'b1);
        check(!settling, "R4", "settling after skip", int'(settling), 0);
        drained("R4");

        // R6 R3: both edges, ceiling 60
        cur_tag = "R6";
        set_cfg(M_BOTH, 0, 10, 60, 0, 30, 1'b0);
        ivq = '{30, 70, 60, 61, 40};
        play(M_BOTH, 1'b1);
        drained("R6");

        // R3: strobe mode, sync_in toggling is noise
        cur_tag = "R3";
        set_cfg(M_OFF, 0, 2, MAXV, 0, 20, 1'b0);
        ivq = '{20, 25};
        play(M_OFF, 1'b1);
        drained("R3");

        // R8: settings change mid-group restarts the monitor
        cur_tag = "R8";
        set_cfg(M_RISE, 1, 5, MAXV, 0, 100, 1'b0);
        ivq = '{100};
        play(M_RISE, 1'b1);
        cfg_nominal = IW'(200); m_nom = 200;
        repeat (3) @(negedge clk);
        check(settling, "R8", "settling after change", int'(settling), 1);
        ivq = '{200, 210};
        play(M_RISE, 1'b1);
        drained("R8");

        // R9: disabled monitor stays quiet
        set_cfg(M_RISE, 0, 0, MAXV, 0, 30, 1'b0);
        cfg_enable = 1'b0;
        repeat (3) @(negedge clk);
        ivq = '{30, 30, 30};
        play(M_RISE, 1'b0);
        check(!settling, "R9", "settling while disabled", int'(settling), 0);
        drained("R9");

        // R10: counter saturation
        cur_tag = "R10";
        set_cfg(M_RISE, 0, 0, MAXV, 0, MAXV, 1'b0);
        ivq = '{1030};
        play(M_RISE, 1'b1);
        drained("R10");

        summary();
    end

endmodule